// File: doc/BRIEF.md
# Three-Fan Tachometer with Power-of-Two Divisors

The block measures the speed of three fans by timing their tachometer pulses against a reference time base. Each fan input is synchronized and its rising edges are found. A measurement window runs from one rising edge over a programmable number of fan periods. During the window, the block counts the cycles in which the reference tick input is high. When the window closes, the count is published on the fan's lane of the count output, and the next window opens on that same edge.

Each fan works in one of two modes. In the narrow mode, the count is clamped to 8 bits and the window length comes from a divisor configuration word. Fans 1 and 2 each have a 3-bit exponent field in that word. Fan 3 has a single bit that selects one of two divisors. In the wide mode, which is enabled per fan, the count is 16 bits and the window length is fixed at two fan periods.

A count at all-ones marks a fan that is stalled or too slow. This value is published as soon as the running count reaches the limit, without waiting for the window to close. A count of zero means that no measurement has been made. Software converts counts to speed and chooses the divisors.

Top module: `fan_tach`

## Requirements
- R1: Each fan input passes through a two-flop synchronizer. Only its rising transitions are counted as fan edges.
- R2: Windows follow each other with no gap. A window's count is the number of cycles with `ref_tick_i` high strictly between its opening edge and its closing edge. With the tick held high, a window of N fan periods of P clocks each yields N*P-1.
- R3: In narrow mode, fan k (k=0,1) closes its window after 2^e fan periods, where e is `div_cfg_i[3k+2:3k]`.
- R4: In narrow mode, fan 2 uses `div_cfg_i[6]` alone: 0 gives a window of 2 periods and 1 gives a window of 8 periods.
- R5: In narrow mode, the published count is clamped to 0x00FF. When the running count reaches 0x00FF before the window closes, 0x00FF is published at once.
- R6: When `ext_en_i[k]` is 1, fan k counts in 16 bits with a fixed window of 2 periods, whatever the value of its divisor field. Its count saturates at 0xFFFF, which is also published at once.
- R7: After reset every lane reads 0. A fan lane stays 0 until that fan has both opened and closed a window.
- R8: A lane changes only when its window closes or when its count saturates. Otherwise it holds its value. Each fan is independent of the other two.
- R9: Cycles in which `ref_tick_i` is low add nothing to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference time-base enable, counted while high |
| fan_i | input | 3 | Asynchronous tachometer inputs, bit k is fan k |
| div_cfg_i | input | 7 | Divisor fields: [2:0] fan 0, [5:3] fan 1, [6] fan 2 |
| ext_en_i | input | 3 | Per-fan 16-bit mode enable |
| count_o | output | 48 | Published counts, fan k on [16k+15:16k] |

## Verification
Two events can fall in the same cycle: a window closing on a fan edge, and the running count reaching its saturation limit. The bench provokes this in narrow mode with a 256-clock fan period at divisor 1, so the count reaches 0xFF exactly on the closing edge. It judges the result by expecting 0x00FF. A 255-clock period next to it must read 0x00FE. Lanes running at the same time with other settings must keep their own values.

// File: rtl/fantach_pkg.sv
package fantach_pkg;

  // Effective window exponent for one fan
  function automatic logic [2:0] eff_exp(input int idx, input int nfans,
                                         input logic [31:0] cfg, input logic ext);
    logic [2:0] e;
    if (ext)                 e = 3'd1;
    else if (idx < nfans - 1) e = cfg[3*idx +: 3];
    else                     e = cfg[3*(nfans-1)] ? 3'd3 : 3'd1;
    return e;
  endfunction

endpackage

// File: rtl/fantach_sync.sv
module fantach_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R1: a rising edge needs a low sample in between
  a_r1_edge_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fantach_chan.sv
module fantach_chan #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int EXP_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             tick_i,
  input  logic             ext_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int MAX_DIV = 1 << ((1 << EXP_W) - 1);
  localparam int EDGE_W  = $clog2(MAX_DIV + 1);
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << NARROW_W) - 1);
  localparam logic [CNT_W-1:0] WIDE_MAX   = '1;

  logic              armed_q;
  logic [CNT_W-1:0]  acc_q, cnt_q, limit, acc_inc, acc_clamp;
  logic [EDGE_W-1:0] edges_q;
  logic [EDGE_W:0]   ndiv;
  logic              win_end, at_limit;

  assign limit     = ext_i ? WIDE_MAX : NARROW_MAX;
  assign at_limit  = acc_q >= limit;
  assign acc_inc   = at_limit ? limit : acc_q + CNT_W'(tick_i);
  assign acc_clamp = at_limit ? limit : acc_q;
  assign ndiv      = (EDGE_W+1)'(1) << exp_i;
  assign win_end   = armed_q && rise_i && (({1'b0, edges_q} + 1'b1) >= ndiv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      acc_q   <= '0;
      edges_q <= '0;
      cnt_q   <= '0;
    end else if (rise_i && !armed_q) begin
      armed_q <= 1'b1;
      acc_q   <= '0;
      edges_q <= '0;
    end else if (win_end) begin
      cnt_q   <= acc_clamp;
      acc_q   <= '0;
      edges_q <= '0;
    end else if (armed_q) begin
      acc_q <= acc_inc;
      if (rise_i) edges_q <= edges_q + 1'b1;
      if (at_limit) cnt_q <= limit;  // stall: publish early
    end
  end

  assign cnt_o = cnt_q;

  // R2: opening edge starts an empty window
  a_r2_open_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !armed_q) |=> (armed_q && acc_q == '0));

  // R7: nothing published before the first edge
  a_r7_zero_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> cnt_q == '0);

  // R8: output holds without an edge or a saturated count
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !at_limit) |=> $stable(cnt_q));

  // R5: narrow limit reached mid-window is published next cycle
  a_r5_stall_publish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_i && armed_q && !rise_i && acc_q >= NARROW_MAX) |=> cnt_q == NARROW_MAX);

endmodule

// File: rtl/fan_tach.sv
module fan_tach #(
  parameter int NUM_FANS = 3,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int EXP_W    = 3,
  localparam int CFG_W   = EXP_W * (NUM_FANS - 1) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ref_tick_i,
  input  logic [NUM_FANS-1:0]       fan_i,
  input  logic [CFG_W-1:0]          div_cfg_i,
  input  logic [NUM_FANS-1:0]       ext_en_i,
  output logic [NUM_FANS*CNT_W-1:0] count_o
);
  import fantach_pkg::*;

  for (genvar k = 0; k < NUM_FANS; k++) begin : g_fan
    logic             rise;
    logic [EXP_W-1:0] exp_k;

    assign exp_k = EXP_W'(eff_exp(k, NUM_FANS, 32'(div_cfg_i), ext_en_i[k]));

    fantach_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(fan_i[k]),
      .rise_o (rise)
    );

    fantach_chan #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .EXP_W(EXP_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise),
      .tick_i (ref_tick_i),
      .ext_i  (ext_en_i[k]),
      .exp_i  (exp_k),
      .cnt_o  (count_o[k*CNT_W +: CNT_W])
    );
  end

endmodule

// File: tb/fan_tach_test.sv
module fan_tach_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [2:0]  fan_w;
  logic [6:0]  div_cfg = '0;
  logic [2:0]  ext_en = '0;
  logic [47:0] count;
  int          per [3] = '{0, 0, 0};
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fan_tach uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick), .fan_i(fan_w),
    .div_cfg_i(div_cfg), .ext_en_i(ext_en), .count_o(count)
  );

  for (genvar k = 0; k < 3; k++) begin : g_gen
    logic f = 1'b0;
    assign fan_w[k] = f;
    always begin
      if (per[k] == 0) begin
        f = 1'b0;
        @(negedge clk);
      end else begin
        f = 1'b1;
        repeat (per[k] / 2) @(negedge clk);
        f = 1'b0;
        repeat (per[k] - per[k] / 2) @(negedge clk);
      end
    end
  end

  typedef struct packed {
    logic [6:0]  div;
    logic [2:0]  ext;
    logic [15:0] p0, p1, p2, e0, e1, e2;
  } vec_t;

  // expected = min(D*P-1, limit)
  localparam vec_t VECS [6] = '{
    '{7'h00, 3'b000, 16'd10,  16'd20,  16'd30,  16'd9,   16'd19,  16'd59},   // R2 R3 R4
    '{7'h53, 3'b000, 16'd6,   16'd8,   16'd4,   16'd47,  16'd31,  16'd31},   // R3 R4
    '{7'h00, 3'b000, 16'd256, 16'd255, 16'd128, 16'd255, 16'd254, 16'd255},  // R5 boundary
    '{7'h2F, 3'b000, 16'd4,   16'd10,  16'd200, 16'd255, 16'd255, 16'd255},  // R5 clamp
    '{7'h2F, 3'b111, 16'd300, 16'd150, 16'd700, 16'd599, 16'd299, 16'd1399}, // R6
    '{7'h41, 3'b010, 16'd200, 16'd200, 16'd50,  16'd255, 16'd399, 16'd255}   // R6 R8 mixed
  };

  task automatic check(input string req, input int lane, input logic [15:0] exp_v);
    logic [15:0] act;
    act = count[lane*16 +: 16];
    n_checks++;
    if (act !== exp_v) begin
      n_errors++;
      $display("FAIL %s lane %0d actual %0d expected %0d", req, lane, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // R7: reset state and no edges
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (1000) @(negedge clk);
    for (int k = 0; k < 3; k++) check("R7 idle zero", k, 16'd0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      div_cfg = VECS[v].div;
      ext_en  = VECS[v].ext;
      per[0] = int'(VECS[v].p0);
      per[1] = int'(VECS[v].p1);
      per[2] = int'(VECS[v].p2);
      do_reset();
      repeat (6000) @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6 vec %0d", v), 0, VECS[v].e0);
      check($sformatf("R2/R3/R4/R5/R6 vec %0d", v), 1, VECS[v].e1);
      check($sformatf("R2/R3/R4/R5/R6 vec %0d", v), 2, VECS[v].e2);
    end

    // R5 R8: narrow stall on fan 0, others unaffected
    div_cfg = '0; ext_en = '0;
    per[0] = 20; per[1] = 20; per[2] = 20;
    do_reset();
    repeat (300) @(negedge clk);
    check("R2 steady", 0, 16'd19);
    per[0] = 0;
    repeat (400) @(negedge clk);
    check("R5 narrow stall", 0, 16'd255);
    check("R8 independent lane", 1, 16'd19);
    check("R8 independent lane", 2, 16'd39);

    // R9: tick low adds nothing
    tick = 1'b0;
    repeat (200) @(negedge clk);
    check("R9 tick gated", 1, 16'd0);
    tick = 1'b1;
    repeat (200) @(negedge clk);
    check("R9 tick restored", 1, 16'd19);

    // R6: wide stall saturates at 0xFFFF
    ext_en = 3'b001;
    per[0] = 100; per[1] = 0; per[2] = 0;
    do_reset();
    repeat (1000) @(negedge clk);
    check("R6 wide count", 0, 16'd199);
    per[0] = 0;
    repeat (66000) @(negedge clk);
    check("R6 wide stall", 0, 16'hFFFF);
    check("R7 no edge lane", 1, 16'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule